// File: doc/BRIEF.md
# Flash Controller Status and Clock-Divider Registers

This block is the software-visible register pair of a nonvolatile-memory controller. It sits on a byte-wide bus that is synchronous to the controller clock. The bus has an address, a write enable, write data and combinational read data. The first register holds event flags. Hardware pulses set these flags, and software clears a flag by writing a one to its bit. The second register holds the programming clock divider. It takes only the first write after reset and then locks.

The flag that reports an empty command buffer also triggers execution. When software clears it, the block emits a one-cycle launch strobe toward the command sequencer. The flag stays low until the sequencer reports completion with a pulse. A hardware set and a software clear can land on the same flag in the same cycle; the set wins, so no event is lost. Software that reads the status register and writes the value back clears every flag that was set, including the buffer-empty flag, which starts a command.

Top module: `nvm_ctl_regs`

## Requirements
- R1: After reset, the status register (address 0) reads 0x80, the divider register (address 1) reads 0x00 and `cmd_launch` is low.
- R2: Writing the status register clears each flag whose bit is 1 in the write data. Flags whose write-data bit is 0 keep their value.
- R3: A pulse on `hw_done`, `hw_acc_err` or `hw_prot_viol` sets bit 7, bit 4 or bit 5 of the status register respectively, visible from the next cycle.
- R4: When a hardware set and a software clear of the same flag fall in the same cycle, the flag stays 1. Other flags cleared in that write still clear.
- R5: Status bits 6 and 3..0 always read 0. Writes to them, including bit 0, have no effect.
- R6: A write that clears the set bit 7 makes `cmd_launch` high for exactly the following cycle. Writing 1 to bit 7 while it is already 0 produces no strobe, and neither does a write that loses to `hw_done`.
- R7: Writing back a value read from the status register clears all flags that were set in it and starts a command launch.
- R8: The first write to address 1 after reset loads the prescale bit (bit 6) and the divider field (bits 5..0). From the next cycle, address 1 reads bit 7 as 1, and `div_loaded`, `div_pre8` and `div_value` reflect the stored fields.
- R9: Once loaded, the divider register ignores further writes until reset.
- R10: Unmapped addresses read 0, and writes to them change neither register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller and bus clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W | Register address |
| bus_we | input | 1 | Write enable, one write per high cycle |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr`, combinational |
| hw_done | input | 1 | Command completion pulse, sets buffer-empty flag |
| hw_acc_err | input | 1 | Access-error event pulse |
| hw_prot_viol | input | 1 | Protection-violation event pulse |
| cmd_launch | output | 1 | One-cycle strobe when buffer-empty flag is cleared |
| div_loaded | output | 1 | Divider register has been written and locked |
| div_pre8 | output | 1 | Stored prescale-by-8 enable |
| div_value | output | 6 | Stored divider field |

## Verification
The status register is driven with several write patterns:
- writes of zeros;
- a single-bit mask;
- masks that touch only unused bits;
- a full read-back-and-write-back.

These patterns separate true write-one-to-clear behaviour from write-zero-to-clear and plain-store behaviour, and they expose the clearing side effect of a read-modify-write. Hardware pulses are also raised in the same cycle as a clearing write. This shows whether set priority holds per bit, rather than the whole write being dropped. The launch strobe is checked after a real clear, after a redundant clear of an already-empty flag, and after a clear that loses to `hw_done`.

The divider is written twice, then reset and written again, to confirm that it locks on the first write and unlocks only on reset.

// File: rtl/nvm_regs_pkg.sv
package nvm_regs_pkg;

    localparam int DATA_W  = 8;
    localparam int NFLAG   = 3;

    // status bit positions (software decodes these)
    localparam int POS_AE  = 4;
    localparam int POS_PV  = 5;
    localparam int POS_CBE = 7;

    // divider register layout
    localparam int DIVF_W   = 6;
    localparam int POS_PRE  = 6;
    localparam int POS_LOCK = 7;

    // flag vector index order: [2]=buffer empty, [1]=prot viol, [0]=access err
    localparam int IDX_AE  = 0;
    localparam int IDX_PV  = 1;
    localparam int IDX_CBE = 2;

    typedef struct packed {
        logic cbe;
        logic pviol;
        logic accerr;
    } nvm_flags_t;

    typedef struct packed {
        logic              lock;
        logic              pre8;
        logic [DIVF_W-1:0] val;
    } nvm_div_t;

    function automatic int flag_pos(input int idx);
        case (idx)
            IDX_AE:  return POS_AE;
            IDX_PV:  return POS_PV;
            default: return POS_CBE;
        endcase
    endfunction

    function automatic logic flag_rst_val(input int idx);
        return (idx == IDX_CBE);
    endfunction

    function automatic logic [DATA_W-1:0] pack_status(input nvm_flags_t f);
        logic [DATA_W-1:0] b;
        b          = '0;
        b[POS_CBE] = f.cbe;
        b[POS_PV]  = f.pviol;
        b[POS_AE]  = f.accerr;
        return b;
    endfunction

endpackage

// File: rtl/nvm_w1c_cell.sv
module nvm_w1c_cell #(
    parameter logic RST_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst,
    input  logic hw_set,
    input  logic sw_clr,
    output logic q,
    output logic clr_taken
);
    // a clear only takes effect on a set flag and when no set competes
    assign clr_taken = sw_clr & q & ~hw_set;

    always_ff @(posedge clk) begin
        if (rst)            q <= RST_VAL;
        else if (hw_set)    q <= 1'b1;
        else if (sw_clr)    q <= 1'b0;
    end
endmodule

// File: rtl/nvm_stat_reg.sv
module nvm_stat_reg
    import nvm_regs_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_stat,
    input  logic [DATA_W-1:0] wdata,
    input  logic [NFLAG-1:0]  hw_set,
    output logic [NFLAG-1:0]  flags,
    output logic              launch
);
    logic [NFLAG-1:0] clr_req;
    logic [NFLAG-1:0] clr_taken;

    for (genvar i = 0; i < NFLAG; i++) begin : g_flag
        assign clr_req[i] = wr_stat & wdata[flag_pos(i)];

        nvm_w1c_cell #(
            .RST_VAL (flag_rst_val(i))
        ) u_cell (
            .clk       (clk),
            .rst       (rst),
            .hw_set    (hw_set[i]),
            .sw_clr    (clr_req[i]),
            .q         (flags[i]),
            .clr_taken (clr_taken[i])
        );
    end

    always_ff @(posedge clk) begin
        if (rst) launch <= 1'b0;
        else     launch <= clr_taken[IDX_CBE];
    end
endmodule

// File: rtl/nvm_div_reg.sv
module nvm_div_reg
    import nvm_regs_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_div,
    input  logic [DATA_W-1:0] wdata,
    output nvm_div_t          div_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            div_q <= '0;
        end else if (wr_div && !div_q.lock) begin
            div_q.lock <= 1'b1;
            div_q.pre8 <= wdata[POS_PRE];
            div_q.val  <= wdata[DIVF_W-1:0];
        end
    end
endmodule

// File: rtl/nvm_ctl_regs.sv
module nvm_ctl_regs
    import nvm_regs_pkg::*;
#(
    parameter int ADDR_W    = 2,
    parameter int STAT_ADDR = 0,
    parameter int DIV_ADDR  = 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [7:0]        bus_wdata,
    output logic [7:0]        bus_rdata,
    input  logic              hw_done,
    input  logic              hw_acc_err,
    input  logic              hw_prot_viol,
    output logic              cmd_launch,
    output logic              div_loaded,
    output logic              div_pre8,
    output logic [5:0]        div_value
);
    localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(STAT_ADDR);
    localparam logic [ADDR_W-1:0] A_DIV  = ADDR_W'(DIV_ADDR);

    logic             sel_stat, sel_div;
    logic [NFLAG-1:0] hw_set;
    logic [NFLAG-1:0] flags;
    nvm_flags_t       flag_s;
    nvm_div_t         div_q;

    assign sel_stat = (bus_addr == A_STAT);
    assign sel_div  = (bus_addr == A_DIV);

    always_comb begin
        hw_set          = '0;
        hw_set[IDX_AE]  = hw_acc_err;
        hw_set[IDX_PV]  = hw_prot_viol;
        hw_set[IDX_CBE] = hw_done;
    end

    nvm_stat_reg u_stat (
        .clk     (clk),
        .rst     (rst),
        .wr_stat (bus_we & sel_stat),
        .wdata   (bus_wdata),
        .hw_set  (hw_set),
        .flags   (flags),
        .launch  (cmd_launch)
    );

    nvm_div_reg u_div (
        .clk    (clk),
        .rst    (rst),
        .wr_div (bus_we & sel_div),
        .wdata  (bus_wdata),
        .div_q  (div_q)
    );

    always_comb begin
        flag_s.cbe    = flags[IDX_CBE];
        flag_s.pviol  = flags[IDX_PV];
        flag_s.accerr = flags[IDX_AE];
    end

    always_comb begin
        if (sel_stat)     bus_rdata = pack_status(flag_s);
        else if (sel_div) bus_rdata = div_q;
        else              bus_rdata = '0;
    end

    assign div_loaded = div_q.lock;
    assign div_pre8   = div_q.pre8;
    assign div_value  = div_q.val;
endmodule

// File: rtl/nvm_ctl_regs_chk.sv
module nvm_ctl_regs_chk #(
    parameter int ADDR_W    = 2,
    parameter int STAT_ADDR = 0,
    parameter int DIV_ADDR  = 1
) (
    input logic              clk,
    input logic              rst,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_we,
    input logic [7:0]        bus_wdata,
    input logic [7:0]        bus_rdata,
    input logic              hw_done,
    input logic              hw_acc_err,
    input logic              hw_prot_viol,
    input logic              cmd_launch,
    input logic              div_loaded,
    input logic              div_pre8,
    input logic [5:0]        div_value,
    input logic [2:0]        flags
);
    localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(STAT_ADDR);

    AST_ACC_SET_WINS: assert property (@(posedge clk) disable iff (rst)
        hw_acc_err |=> flags[0]); // R4
    AST_CBE_SET_WINS: assert property (@(posedge clk) disable iff (rst)
        hw_done |=> flags[2]); // R3
    AST_ZERO_KEEPS: assert property (@(posedge clk) disable iff (rst)
        (flags[1] && bus_we && bus_addr == A_STAT && !bus_wdata[5]) |=> flags[1]); // R2
    AST_UNUSED_ZERO: assert property (@(posedge clk) disable iff (rst)
        (bus_addr == A_STAT) |-> ((bus_rdata & 8'h4F) == 8'h00)); // R5
    AST_LAUNCH_ON_FALL: assert property (@(posedge clk) disable iff (rst)
        cmd_launch |-> (!flags[2] && $past(flags[2]))); // R6
    AST_LAUNCH_SINGLE: assert property (@(posedge clk) disable iff (rst)
        cmd_launch |=> !cmd_launch); // R6
    AST_DIV_LOCKED: assert property (@(posedge clk) disable iff (rst)
        div_loaded |=> (div_loaded && $stable(div_value) && $stable(div_pre8))); // R9
endmodule

bind nvm_ctl_regs nvm_ctl_regs_chk #(
    .ADDR_W    (ADDR_W),
    .STAT_ADDR (STAT_ADDR),
    .DIV_ADDR  (DIV_ADDR)
) u_chk (
    .clk          (clk),
    .rst          (rst),
    .bus_addr     (bus_addr),
    .bus_we       (bus_we),
    .bus_wdata    (bus_wdata),
    .bus_rdata    (bus_rdata),
    .hw_done      (hw_done),
    .hw_acc_err   (hw_acc_err),
    .hw_prot_viol (hw_prot_viol),
    .cmd_launch   (cmd_launch),
    .div_loaded   (div_loaded),
    .div_pre8     (div_pre8),
    .div_value    (div_value),
    .flags        (flags)
);

// File: tb/nvm_ctl_regs_tb.sv
module nvm_ctl_regs_tb;

    typedef enum logic [1:0] {K_READ, K_LAUNCH, K_DIVP} kind_t;
    typedef struct {
        kind_t      kind;
        logic [7:0] exp;
        string      tag;
    } item_t;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [1:0] bus_addr = '0;
    logic       bus_we = 1'b0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic       hw_done = 1'b0, hw_acc_err = 1'b0, hw_prot_viol = 1'b0;
    logic       cmd_launch, div_loaded, div_pre8;
    logic [5:0] div_value;

    int    n_checks = 0;
    int    n_errors = 0;
    bit    done = 1'b0;
    item_t sb_q[$];

    always #2 clk = ~clk;

    nvm_ctl_regs u_dut (
        .clk          (clk),
        .rst          (rst),
        .bus_addr     (bus_addr),
        .bus_we       (bus_we),
        .bus_wdata    (bus_wdata),
        .bus_rdata    (bus_rdata),
        .hw_done      (hw_done),
        .hw_acc_err   (hw_acc_err),
        .hw_prot_viol (hw_prot_viol),
        .cmd_launch   (cmd_launch),
        .div_loaded   (div_loaded),
        .div_pre8     (div_pre8),
        .div_value    (div_value)
    );

    // monitor: one expected item per cycle, sampled at the falling edge
    initial begin
        forever begin
            @(negedge clk);
            if (sb_q.size() > 0) begin
                item_t it;
                logic [7:0] act;
                it = sb_q.pop_front();
                case (it.kind)
                    K_READ:   act = bus_rdata;
                    K_LAUNCH: act = {7'd0, cmd_launch};
                    default:  act = {div_loaded, div_pre8, div_value};
                endcase
                n_checks++;
                if (act !== it.exp) begin
                    n_errors++;
                    $display("FAIL %s: actual=0x%02h expected=0x%02h", it.tag, act, it.exp);
                end
            end
        end
    end

    task automatic cyc();
        @(posedge clk);
        #1;
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        bus_addr = a; bus_we = 1'b1; bus_wdata = d;
        cyc();
        bus_we = 1'b0;
    endtask

    task automatic pulse(input logic d, input logic ae, input logic pv);
        hw_done = d; hw_acc_err = ae; hw_prot_viol = pv;
        cyc();
        hw_done = 1'b0; hw_acc_err = 1'b0; hw_prot_viol = 1'b0;
    endtask

    task automatic exp_rd(input logic [1:0] a, input logic [7:0] e, input string tag);
        item_t it;
        bus_addr = a;
        it.kind = K_READ; it.exp = e; it.tag = tag;
        sb_q.push_back(it);
        cyc();
    endtask

    task automatic exp_launch(input logic e, input string tag);
        item_t it;
        it.kind = K_LAUNCH; it.exp = {7'd0, e}; it.tag = tag;
        sb_q.push_back(it);
        cyc();
    endtask

    task automatic exp_divp(input logic [7:0] e, input string tag);
        item_t it;
        it.kind = K_DIVP; it.exp = e; it.tag = tag;
        sb_q.push_back(it);
        cyc();
    endtask

    task automatic do_reset();
        rst = 1'b1;
        repeat (3) cyc();
        rst = 1'b0;
    endtask

    initial begin
        cyc();
        do_reset();
        // R1 reset values
        exp_launch(1'b0, "R1");
        exp_rd(2'd0, 8'h80, "R1");
        exp_rd(2'd1, 8'h00, "R1");
        exp_divp(8'h00, "R1");

        // R3 hardware sets
        pulse(1'b0, 1'b1, 1'b1);
        exp_rd(2'd0, 8'hB0, "R3");

        // R2 zero write keeps, one clears only its bit
        wr(2'd0, 8'h00);
        exp_rd(2'd0, 8'hB0, "R2");
        wr(2'd0, 8'h10);
        exp_rd(2'd0, 8'hA0, "R2");

        // R5 unused bits incl. bit 0
        wr(2'd0, 8'h4F);
        exp_rd(2'd0, 8'hA0, "R5");

        // R7 read-modify-write clears all set flags and launches
        pulse(1'b0, 1'b1, 1'b0);
        exp_rd(2'd0, 8'hB0, "R7");
        wr(2'd0, 8'hB0);
        exp_launch(1'b1, "R7");
        exp_launch(1'b0, "R6");
        exp_rd(2'd0, 8'h00, "R7");

        // R6 redundant clear gives no strobe
        wr(2'd0, 8'h80);
        exp_launch(1'b0, "R6");
        pulse(1'b1, 1'b0, 1'b0);
        exp_rd(2'd0, 8'h80, "R3");

        // R4 set beats clear in the same cycle
        pulse(1'b0, 1'b1, 1'b1);
        bus_addr = 2'd0; bus_we = 1'b1; bus_wdata = 8'hB0;
        hw_acc_err = 1'b1; hw_done = 1'b1;
        cyc();
        bus_we = 1'b0; hw_acc_err = 1'b0; hw_done = 1'b0;
        exp_launch(1'b0, "R6");
        exp_rd(2'd0, 8'h90, "R4");

        // R8 first divider write
        wr(2'd1, 8'h45);
        exp_rd(2'd1, 8'hC5, "R8");
        exp_divp(8'hC5, "R8");

        // R9 later writes ignored
        wr(2'd1, 8'h3F);
        exp_rd(2'd1, 8'hC5, "R9");
        exp_divp(8'hC5, "R9");

        // R10 unmapped address
        wr(2'd3, 8'hFF);
        exp_rd(2'd3, 8'h00, "R10");
        exp_rd(2'd0, 8'h90, "R10");
        exp_rd(2'd1, 8'hC5, "R10");

        // reset unlocks divider
        do_reset();
        exp_rd(2'd1, 8'h00, "R1");
        exp_rd(2'd0, 8'h80, "R1");
        wr(2'd1, 8'h0A);
        exp_rd(2'd1, 8'h8A, "R8");
        exp_divp(8'h8A, "R8");

        cyc();
        cyc();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        #(4 * 200000);
        if (!done) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

endmodule